// File: doc/BRIEF.md
# Pipelined Array Add-and-Scale Engine

This block walks two operand arrays of equal length and fills a result array. Each result element is the unsigned sum of the two operands at the same index, divided by four with truncation. A single index counter generates the address. That address is shared by the read port of both operand memories and, after a fixed delay, by the write port of the result memory.

A one-cycle `start` pulse launches a pass over all elements. The operand memories have a synchronous read with one cycle of latency. The arithmetic is split by registers into `STAGES` overlapped stages: two by default, or four in the deeper variant. Once the pipeline has filled, one result is written on every clock. `done` pulses once when the pass is complete.

Top module: `arr_scale_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `rdEn` and `wrEn` are all low.
- R2: A `start` sampled high while idle makes `rdEn` go high for exactly `NUM_ELEM` consecutive cycles, with `rdAddr` stepping 0, 1, 2 … `NUM_ELEM-1`.
- R3: Each written value equals `(A[i] + B[i]) >> 2`, computed as an unsigned sum one bit wider than the operands, so that all-ones operands give `(2*(2^DATA_W-1)) >> 2` and no overflow.
- R4: `wrAddr` equals the element index. Every index from 0 to `NUM_ELEM-1` is written exactly once per pass, in ascending order.
- R5: The first write appears `STAGES+1` clock edges after the edge that samples `start`: one edge for the read latency plus one for each pipeline stage.
- R6: After the first write, `wrEn` stays high for `NUM_ELEM` consecutive cycles, which is one result per clock.
- R7: `done` is high for exactly one cycle, the cycle after the write of index `NUM_ELEM-1`.
- R8: A `start` pulse during a pass, whether in the read phase or while the pipeline drains, is ignored. It causes no extra reads, no extra writes, no second `done`, and no restart after the pass ends.
- R9: With `STAGES=4`, the adder is split at half the operand width across two stages. The results equal those of the two-stage build, and only the fill delay of R5 changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a pass when idle |
| done | output | 1 | One-cycle pulse at the end of a pass |
| rdEn | output | 1 | Read strobe for both operand memories |
| rdAddr | output | IDX_W | Operand read index |
| rdDataA | input | DATA_W | Operand A, valid one cycle after rdEn |
| rdDataB | input | DATA_W | Operand B, valid one cycle after rdEn |
| wrEn | output | 1 | Result write strobe |
| wrAddr | output | IDX_W | Result write index |
| wrData | output | DATA_W | Result value |

## Verification
The bench builds two copies side by side with `DATA_W=8` and `NUM_ELEM=100`, one with `STAGES=2` and one with `STAGES=4`. Both copies read the same operand arrays, so the fill delays of three and five edges and the identical results can be compared directly. Eight-bit operands make the boundary patterns easy to reach: all-ones operands exercise the extra sum bit, and low-nibble operands of 0x0F plus 0x01 force the carry across the split adder of the four-stage build. A second `start` is pulsed during the read phase and again during the drain, to exercise the ignore rule.

// File: rtl/arr_scale_pkg.sv
package arr_scale_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } ctrl_state_t;

  // strobes from control to datapath for the element being read this cycle
  typedef struct packed {
    logic issue;      // an operand read is being issued
    logic lastIssue;  // it is the final element of the pass
  } ctrl_strobe_t;

endpackage

// File: rtl/arr_scale_ctrl.sv
module arr_scale_ctrl
  import arr_scale_pkg::*;
#(
  parameter int NUM_ELEM = 100,
  parameter int IDX_W    = $clog2(NUM_ELEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             retireLast,
  output ctrl_strobe_t     strobe,
  output logic [IDX_W-1:0] idx,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ELEM - 1);

  ctrl_state_t      state;
  logic [IDX_W-1:0] cnt;
  logic             issuing;

  assign issuing          = (state == ST_ISSUE);
  assign idx              = cnt;
  assign strobe.issue     = issuing;
  assign strobe.lastIssue = issuing && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_ISSUE;
            cnt   <= '0;
          end
        end
        ST_ISSUE: begin
          if (cnt == LAST_IDX) state <= ST_DRAIN;
          else                 cnt   <= cnt + 1'b1;
        end
        ST_DRAIN: begin
          if (retireLast) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/arr_scale_dp.sv
module arr_scale_dp
  import arr_scale_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 7,
  parameter int STAGES = 2   // 2 or 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strobe_t      strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] rdDataA,
  input  logic [DATA_W-1:0] rdDataB,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              retireLast
);

  localparam int SUM_W = DATA_W + 1;
  localparam int Q_W   = SUM_W - 2;
  localparam int LO_W  = DATA_W / 2;
  localparam int HI_W  = DATA_W - LO_W;

  // sideband aligned with the memory read latency
  logic             alnVld, alnLast;
  logic [IDX_W-1:0] alnIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      alnVld  <= 1'b0;
      alnLast <= 1'b0;
    end else begin
      alnVld  <= strobe.issue;
      alnLast <= strobe.lastIssue;
    end
    alnIdx <= idx;
  end

  // valid, last and index travel through every stage
  logic [STAGES-1:0] vldPipe, lastPipe;
  logic [IDX_W-1:0]  idxPipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_side
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          vldPipe[g]  <= 1'b0;
          lastPipe[g] <= 1'b0;
        end else begin
          vldPipe[g]  <= alnVld;
          lastPipe[g] <= alnLast;
        end
        idxPipe[g] <= alnIdx;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) begin
          vldPipe[g]  <= 1'b0;
          lastPipe[g] <= 1'b0;
        end else begin
          vldPipe[g]  <= vldPipe[g-1];
          lastPipe[g] <= lastPipe[g-1];
        end
        idxPipe[g] <= idxPipe[g-1];
      end
    end
  end

  logic [Q_W-1:0] resQ;

  if (STAGES == 4) begin : g_deep
    logic [LO_W:0]      s1Lo;
    logic [HI_W-1:0]    s1HiA, s1HiB;
    logic [SUM_W-1:0]   s2Sum;
    logic [Q_W-1:0]     s3Q, s4Q;

    always_ff @(posedge clk) begin
      s1Lo  <= {1'b0, rdDataA[LO_W-1:0]} + {1'b0, rdDataB[LO_W-1:0]};
      s1HiA <= rdDataA[DATA_W-1:LO_W];
      s1HiB <= rdDataB[DATA_W-1:LO_W];
      s2Sum <= {({1'b0, s1HiA} + {1'b0, s1HiB} + {{HI_W{1'b0}}, s1Lo[LO_W]}),
                s1Lo[LO_W-1:0]};
      s3Q   <= s2Sum[SUM_W-1:2];
      s4Q   <= s3Q;
    end
    assign resQ = s4Q;
  end else begin : g_shallow
    logic [SUM_W-1:0] s1Sum;
    logic [Q_W-1:0]   s2Q;

    always_ff @(posedge clk) begin
      s1Sum <= {1'b0, rdDataA} + {1'b0, rdDataB};
      s2Q   <= s1Sum[SUM_W-1:2];
    end
    assign resQ = s2Q;
  end

  assign wrEn       = vldPipe[STAGES-1];
  assign wrAddr     = idxPipe[STAGES-1];
  assign wrData     = {{(DATA_W-Q_W){1'b0}}, resQ};
  assign retireLast = vldPipe[STAGES-1] && lastPipe[STAGES-1];

endmodule

// File: rtl/arr_scale_top.sv
module arr_scale_top
  import arr_scale_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_ELEM = 100,
  parameter int STAGES   = 2,
  parameter int IDX_W    = $clog2(NUM_ELEM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic              rdEn,
  output logic [IDX_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0] rdDataA,
  input  logic [DATA_W-1:0] rdDataB,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrAddr,
  output logic [DATA_W-1:0] wrData
);

  ctrl_strobe_t     strobe;
  logic [IDX_W-1:0] idx;
  logic             retireLast;

  arr_scale_ctrl #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .retireLast(retireLast),
    .strobe(strobe), .idx(idx), .done(done)
  );

  arr_scale_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W), .STAGES(STAGES)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .idx(idx),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .retireLast(retireLast)
  );

  assign rdEn   = strobe.issue;
  assign rdAddr = idx;

endmodule

// File: rtl/arr_scale_chk.sv
module arr_scale_chk #(
  parameter int NUM_ELEM = 100,
  parameter int IDX_W    = $clog2(NUM_ELEM)
) (
  input logic             clk,
  input logic             rst,
  input logic             done,
  input logic             rdEn,
  input logic [IDX_W-1:0] rdAddr,
  input logic             wrEn,
  input logic [IDX_W-1:0] wrAddr
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ELEM - 1);

  assert_rd_stream_R2: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdAddr != LAST_IDX) |=> (rdEn && rdAddr == $past(rdAddr) + 1'b1));

  assert_rd_range_R2: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> (rdAddr <= LAST_IDX));

  assert_wr_stream_R6: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != LAST_IDX) |=> (wrEn && wrAddr == $past(wrAddr) + 1'b1));

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == LAST_IDX) |=> done);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_quiet_at_done_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!wrEn && !rdEn));

endmodule

bind arr_scale_top arr_scale_chk #(.NUM_ELEM(NUM_ELEM)) u_chk (
  .clk(clk), .rst(rst), .done(done), .rdEn(rdEn), .rdAddr(rdAddr),
  .wrEn(wrEn), .wrAddr(wrAddr)
);

// File: tb/arr_scale_top_tb.sv
module arr_scale_top_tb;

  localparam int DW = 8;
  localparam int NE = 100;
  localparam int IW = $clog2(NE);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [DW-1:0] memA [NE];
  logic [DW-1:0] memB [NE];

  logic done2, rdEn2, wrEn2, done4, rdEn4, wrEn4;
  logic [IW-1:0] rdAddr2, wrAddr2, rdAddr4, wrAddr4;
  logic [DW-1:0] rdA2, rdB2, wrData2, rdA4, rdB4, wrData4;

  arr_scale_top #(.DATA_W(DW), .NUM_ELEM(NE), .STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .start(start), .done(done2), .rdEn(rdEn2),
    .rdAddr(rdAddr2), .rdDataA(rdA2), .rdDataB(rdB2),
    .wrEn(wrEn2), .wrAddr(wrAddr2), .wrData(wrData2));

  arr_scale_top #(.DATA_W(DW), .NUM_ELEM(NE), .STAGES(4)) u_dut4 (
    .clk(clk), .rst(rst), .start(start), .done(done4), .rdEn(rdEn4),
    .rdAddr(rdAddr4), .rdDataA(rdA4), .rdDataB(rdB4),
    .wrEn(wrEn4), .wrAddr(wrAddr4), .wrData(wrData4));

  // synchronous operand memories, one cycle latency
  always @(posedge clk) begin
    if (rdEn2) begin rdA2 <= memA[rdAddr2]; rdB2 <= memB[rdAddr2]; end
    if (rdEn4) begin rdA4 <= memA[rdAddr4]; rdB4 <= memB[rdAddr4]; end
  end

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [IW+DW-1:0] q2[$], q4[$];
  int startCyc = 0, expRd2 = 0, expRd4 = 0;
  int lastWr2 = -10, lastWr4 = -10, prevWr2 = -10, prevWr4 = -10;
  int doneCnt2 = 0, doneCnt4 = 0;
  bit first2 = 0, first4 = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor
  always @(negedge clk) if (!rst) begin
    if (rdEn2) begin chk(int'(rdAddr2) == expRd2, "R2", "rdAddr stg2", int'(rdAddr2), expRd2); expRd2++; end
    if (rdEn4) begin chk(int'(rdAddr4) == expRd4, "R2", "rdAddr stg4", int'(rdAddr4), expRd4); expRd4++; end
    if (wrEn2) begin
      logic [IW+DW-1:0] e;
      if (first2) begin chk(cyc == startCyc + 3, "R5", "fill stg2", cyc - startCyc, 3); first2 = 0; end
      else chk(cyc == prevWr2 + 1, "R6", "gap stg2", cyc - prevWr2, 1);
      prevWr2 = cyc;
      if (q2.size() == 0) chk(0, "R8", "extra write stg2", int'(wrAddr2), -1);
      else begin
        e = q2.pop_front();
        chk(wrAddr2 == e[IW+DW-1:DW], "R4", "wrAddr stg2", int'(wrAddr2), int'(e[IW+DW-1:DW]));
        chk(wrData2 == e[DW-1:0], "R3", "wrData stg2", int'(wrData2), int'(e[DW-1:0]));
      end
      if (int'(wrAddr2) == NE-1) lastWr2 = cyc;
    end
    if (wrEn4) begin
      logic [IW+DW-1:0] e;
      if (first4) begin chk(cyc == startCyc + 5, "R5", "fill stg4", cyc - startCyc, 5); first4 = 0; end
      else chk(cyc == prevWr4 + 1, "R6", "gap stg4", cyc - prevWr4, 1);
      prevWr4 = cyc;
      if (q4.size() == 0) chk(0, "R8", "extra write stg4", int'(wrAddr4), -1);
      else begin
        e = q4.pop_front();
        chk(wrAddr4 == e[IW+DW-1:DW], "R9", "wrAddr stg4", int'(wrAddr4), int'(e[IW+DW-1:DW]));
        chk(wrData4 == e[DW-1:0], "R9", "wrData stg4", int'(wrData4), int'(e[DW-1:0]));
      end
      if (int'(wrAddr4) == NE-1) lastWr4 = cyc;
    end
    if (done2) begin chk(lastWr2 == cyc - 1, "R7", "done stg2 delay", cyc - lastWr2, 1); doneCnt2++; end
    if (done4) begin chk(lastWr4 == cyc - 1, "R7", "done stg4 delay", cyc - lastWr4, 1); doneCnt4++; end
  end

  // watchdog
  always @(negedge clk) if (cyc > 20000) begin
    chk(0, "WDOG", "watchdog expired", cyc, 20000);
    finish_run();
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_pass(input int pat, input int runIdx);
    for (int i = 0; i < NE; i++) begin
      case (pat)
        0: begin memA[i] = DW'(i);   memB[i] = DW'(2*i); end
        1: begin memA[i] = 8'hFF;    memB[i] = 8'hFF;    end
        2: begin memA[i] = DW'($urandom); memB[i] = DW'($urandom); end
        default: begin memA[i] = 8'h0F | DW'(i << 4); memB[i] = 8'h01; end
      endcase
      begin
        logic [DW:0] s = {1'b0, memA[i]} + {1'b0, memB[i]};
        logic [DW-1:0] r = DW'(s >> 2);
        q2.push_back({IW'(i), r});
        q4.push_back({IW'(i), r});
      end
    end
    expRd2 = 0; expRd4 = 0; first2 = 1; first4 = 1;
    startCyc = cyc + 1;
    pulse_start();
    if (pat == 0) begin
      repeat (30) @(negedge clk);
      pulse_start();            // R8: during read phase
      repeat (70) @(negedge clk);
      pulse_start();            // R8: during drain
    end
    while (doneCnt2 <= runIdx || doneCnt4 <= runIdx) @(negedge clk);
    repeat (6) begin
      @(negedge clk);
      chk(!rdEn2 && !rdEn4, "R8", "no restart read", int'(rdEn2 | rdEn4), 0);
      chk(!wrEn2 && !wrEn4, "R8", "no restart write", int'(wrEn2 | wrEn4), 0);
    end
    chk(expRd2 == NE, "R2", "read count stg2", expRd2, NE);
    chk(expRd4 == NE, "R2", "read count stg4", expRd4, NE);
    chk(q2.size() == 0, "R4", "pending stg2", q2.size(), 0);
    chk(q4.size() == 0, "R4", "pending stg4", q4.size(), 0);
    chk(doneCnt2 == runIdx + 1, "R7", "done count stg2", doneCnt2, runIdx + 1);
    chk(doneCnt4 == runIdx + 1, "R7", "done count stg4", doneCnt4, runIdx + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done2 && !rdEn2 && !wrEn2, "R1", "reset outputs stg2", int'({done2, rdEn2, wrEn2}), 0);
    chk(!done4 && !rdEn4 && !wrEn4, "R1", "reset outputs stg4", int'({done4, rdEn4, wrEn4}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done2 && !rdEn2 && !wrEn2, "R1", "after reset stg2", int'({done2, rdEn2, wrEn2}), 0);
    run_pass(0, 0);
    run_pass(1, 1);
    run_pass(3, 2);
    run_pass(2, 3);
    finish_run();
  end

endmodule